// File: doc/BRIEF.md
# Video Stream Crossbar Switch

The block connects several packetized video input streams to several video output streams. Each stream carries pixel data with valid, ready, start-of-packet and end-of-packet signals. Routing is purely a selection: pixels pass through unchanged, in the same cycle, from the chosen input to each output. The block holds no pixel storage.

Software programs the routing through a small register port. Each output has a staged selection register. Writing a staged register does not disturb the traffic that is flowing. A separate commit register raises a pending request. The request is applied on the first cycle in which no routed output is inside a packet. A frame therefore never mixes beats from two sources. In the commit cycle itself, no beat moves, so a packet that starts afterwards already follows the new routing. A global enable bit gates all traffic.

Top module: `vid_xbar`

## Requirements
- R1: After reset every output valid and every input ready is low, and the enable, commit and selection registers all read 0.
- R2: Bit 0 at address 0 is the enable. While it is 0, no output asserts valid and no input asserts ready.
- R3: Writing address 3+k sets the staged selection of output k, which reads back at once but leaves the active routing unchanged until a commit is applied.
- R4: Writing a value with bit 0 set to address 2 raises a commit request. Address 2 reads 1 while the request is pending and 0 once it has been applied.
- R5: A pending commit is applied in the first cycle in which no routed output is inside a packet. In that cycle no beat is transferred. From the next cycle the staged selections are the active routing.
- R6: A packet is inside an output from an accepted start-of-packet beat that is not also an end until its accepted end-of-packet beat. Every beat of that packet comes from the input it started on, even when a commit is pending.
- R7: Selection value 0 disables an output. A value v from 1 to N_IN selects input v-1. Any value above N_IN also disables the output.
- R8: An input that no enabled output selects is held not-ready.
- R9: An output with no source keeps valid, start, end and data at 0.
- R10: When several outputs select the same input, the lowest-numbered output owns it. The others behave as having no source.
- R11: An owned output copies its source's valid, data, start and end in the same cycle. The source's ready equals the owning output's ready.
- R12: Read data appears on the register port one cycle after the read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| csr_addr | input | AW | Register address |
| csr_wr | input | 1 | Register write strobe |
| csr_wdata | input | CW | Register write data |
| csr_rd | input | 1 | Register read strobe |
| csr_rdata | output | CW | Registered read data |
| in_valid | input | N_IN | Per-input beat valid |
| in_ready | output | N_IN | Per-input beat accepted |
| in_sop | input | N_IN | Per-input start of packet |
| in_eop | input | N_IN | Per-input end of packet |
| in_data | input | N_IN*DW | Per-input pixel data, input i at bits i*DW upward |
| out_valid | output | N_OUT | Per-output beat valid |
| out_ready | input | N_OUT | Per-output sink ready |
| out_sop | output | N_OUT | Per-output start of packet |
| out_eop | output | N_OUT | Per-output end of packet |
| out_data | output | N_OUT*DW | Per-output pixel data, output k at bits k*DW upward |

## Verification
A vector table sets the routing in several ways: straight, crossed, one output off, both outputs on the same input, an out-of-range code, and an all-off setting. It crosses each routing with mixed valid and ready patterns. This shows whether valid travels forward and ready travels back along the same pair. It also shows whether unselected inputs stay stalled and whether duplicate selections resolve to the lower output. Directed sequences start a packet, stage and commit a swap while the packet is open, and confirm that the remaining beats still come from the first input. The new source appears only after the end beat. A monitor tags every output packet with its source and flags any beat from another input.

// File: rtl/vid_xbar_pkg.sv
package vid_xbar_pkg;
  localparam int unsigned ADDR_CTRL     = 0;
  localparam int unsigned ADDR_COMMIT   = 2;
  localparam int unsigned ADDR_SEL_BASE = 3;

  function automatic int unsigned sel_width(input int unsigned n_in);
    return $clog2(n_in + 1);
  endfunction
endpackage

// File: rtl/vid_xbar_regs.sv
module vid_xbar_regs
  import vid_xbar_pkg::*;
#(
  parameter int N_OUT = 2,
  parameter int SELW  = 2,
  parameter int AW    = 4,
  parameter int CW    = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [AW-1:0]         csr_addr,
  input  logic                  csr_wr,
  input  logic [CW-1:0]         csr_wdata,
  input  logic                  csr_rd,
  output logic [CW-1:0]         csr_rdata,
  input  logic                  all_idle,
  output logic                  en_o,
  output logic                  pend_o,
  output logic                  commit_now_o,
  output logic [N_OUT*SELW-1:0] stg_sel_o,
  output logic [N_OUT*SELW-1:0] act_sel_o
);
  logic                  en_q;
  logic                  pend_q;
  logic [N_OUT*SELW-1:0] stg_q;
  logic [N_OUT*SELW-1:0] act_q;
  logic                  commit_now;
  logic                  wr_commit;
  logic [CW-1:0]         rd_val;

  assign commit_now = pend_q & all_idle;
  assign wr_commit  = csr_wr && (csr_addr == AW'(ADDR_COMMIT)) && csr_wdata[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= 1'b0;
      pend_q <= 1'b0;
      stg_q  <= '0;
      act_q  <= '0;
    end else begin
      if (csr_wr && csr_addr == AW'(ADDR_CTRL)) en_q <= csr_wdata[0];
      for (int k = 0; k < N_OUT; k++) begin
        if (csr_wr && csr_addr == AW'(ADDR_SEL_BASE + k))
          stg_q[k*SELW +: SELW] <= csr_wdata[SELW-1:0];
      end
      pend_q <= (pend_q & ~commit_now) | wr_commit;
      if (commit_now) act_q <= stg_q;
    end
  end

  always_comb begin
    rd_val = '0;
    if (csr_addr == AW'(ADDR_CTRL))   rd_val = CW'(en_q);
    if (csr_addr == AW'(ADDR_COMMIT)) rd_val = CW'(pend_q);
    for (int k = 0; k < N_OUT; k++) begin
      if (csr_addr == AW'(ADDR_SEL_BASE + k)) rd_val = CW'(stg_q[k*SELW +: SELW]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         csr_rdata <= '0;
    else if (csr_rd) csr_rdata <= rd_val;
  end

  assign en_o         = en_q;
  assign pend_o       = pend_q;
  assign commit_now_o = commit_now;
  assign stg_sel_o    = stg_q;
  assign act_sel_o    = act_q;
endmodule

// File: rtl/vid_xbar_track.sv
module vid_xbar_track #(
  parameter int N_OUT = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_OUT-1:0] out_valid,
  input  logic [N_OUT-1:0] out_ready,
  input  logic [N_OUT-1:0] out_sop,
  input  logic [N_OUT-1:0] out_eop,
  output logic [N_OUT-1:0] busy,
  output logic             all_idle
);
  for (genvar k = 0; k < N_OUT; k++) begin : g_trk
    logic fire;
    assign fire = out_valid[k] & out_ready[k];
    always_ff @(posedge clk) begin
      if (rst)                           busy[k] <= 1'b0;
      else if (fire && out_eop[k])       busy[k] <= 1'b0;
      else if (fire && out_sop[k])       busy[k] <= 1'b1;
    end
  end
  assign all_idle = ~|busy;
endmodule

// File: rtl/vid_xbar_route.sv
module vid_xbar_route #(
  parameter int N_IN  = 2,
  parameter int N_OUT = 2,
  parameter int DW    = 24,
  parameter int SELW  = 2
) (
  input  logic [N_OUT*SELW-1:0] act_sel,
  input  logic                  xfer_ok,
  input  logic [N_IN-1:0]       in_valid,
  output logic [N_IN-1:0]       in_ready,
  input  logic [N_IN-1:0]       in_sop,
  input  logic [N_IN-1:0]       in_eop,
  input  logic [N_IN*DW-1:0]    in_data,
  output logic [N_OUT-1:0]      out_valid,
  input  logic [N_OUT-1:0]      out_ready,
  output logic [N_OUT-1:0]      out_sop,
  output logic [N_OUT-1:0]      out_eop,
  output logic [N_OUT*DW-1:0]   out_data
);
  logic [SELW-1:0] eff [N_OUT];

  // ownership: in-range code, not already taken by a lower output
  always_comb begin
    for (int k = 0; k < N_OUT; k++) begin
      logic [SELW-1:0] s;
      logic            ok;
      s  = act_sel[k*SELW +: SELW];
      ok = (s != '0) && (int'(s) <= N_IN);
      for (int j = 0; j < k; j++) begin
        if (act_sel[j*SELW +: SELW] == s) ok = 1'b0;
      end
      eff[k] = ok ? s : '0;
    end
  end

  for (genvar k = 0; k < N_OUT; k++) begin : g_out
    always_comb begin
      out_valid[k]           = 1'b0;
      out_sop[k]             = 1'b0;
      out_eop[k]             = 1'b0;
      out_data[k*DW +: DW]   = '0;
      for (int i = 0; i < N_IN; i++) begin
        if (eff[k] == SELW'(i + 1)) begin
          out_valid[k]         = xfer_ok & in_valid[i];
          out_sop[k]           = in_sop[i];
          out_eop[k]           = in_eop[i];
          out_data[k*DW +: DW] = in_data[i*DW +: DW];
        end
      end
    end
  end

  for (genvar i = 0; i < N_IN; i++) begin : g_in
    always_comb begin
      in_ready[i] = 1'b0;
      for (int k = 0; k < N_OUT; k++) begin
        if (eff[k] == SELW'(i + 1) && out_ready[k]) in_ready[i] = xfer_ok;
      end
    end
  end
endmodule

// File: rtl/vid_xbar.sv
module vid_xbar
  import vid_xbar_pkg::*;
#(
  parameter int N_IN  = 2,
  parameter int N_OUT = 2,
  parameter int DW    = 24,
  parameter int AW    = 4,
  parameter int CW    = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [AW-1:0]       csr_addr,
  input  logic                csr_wr,
  input  logic [CW-1:0]       csr_wdata,
  input  logic                csr_rd,
  output logic [CW-1:0]       csr_rdata,
  input  logic [N_IN-1:0]     in_valid,
  output logic [N_IN-1:0]     in_ready,
  input  logic [N_IN-1:0]     in_sop,
  input  logic [N_IN-1:0]     in_eop,
  input  logic [N_IN*DW-1:0]  in_data,
  output logic [N_OUT-1:0]    out_valid,
  input  logic [N_OUT-1:0]    out_ready,
  output logic [N_OUT-1:0]    out_sop,
  output logic [N_OUT-1:0]    out_eop,
  output logic [N_OUT*DW-1:0] out_data
);
  localparam int SELW = sel_width(N_IN);

  logic                  en_q;
  logic                  pend_q;
  logic                  commit_now;
  logic                  all_idle;
  logic [N_OUT-1:0]      busy;
  logic [N_OUT*SELW-1:0] stg_sel;
  logic [N_OUT*SELW-1:0] act_sel;
  logic                  xfer_ok;

  assign xfer_ok = en_q & ~commit_now;

  vid_xbar_regs #(.N_OUT(N_OUT), .SELW(SELW), .AW(AW), .CW(CW)) u_regs (
    .clk(clk), .rst(rst),
    .csr_addr(csr_addr), .csr_wr(csr_wr), .csr_wdata(csr_wdata),
    .csr_rd(csr_rd), .csr_rdata(csr_rdata),
    .all_idle(all_idle), .en_o(en_q), .pend_o(pend_q),
    .commit_now_o(commit_now), .stg_sel_o(stg_sel), .act_sel_o(act_sel)
  );

  vid_xbar_route #(.N_IN(N_IN), .N_OUT(N_OUT), .DW(DW), .SELW(SELW)) u_route (
    .act_sel(act_sel), .xfer_ok(xfer_ok),
    .in_valid(in_valid), .in_ready(in_ready), .in_sop(in_sop),
    .in_eop(in_eop), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_sop(out_sop),
    .out_eop(out_eop), .out_data(out_data)
  );

  vid_xbar_track #(.N_OUT(N_OUT)) u_track (
    .clk(clk), .rst(rst),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_sop(out_sop), .out_eop(out_eop),
    .busy(busy), .all_idle(all_idle)
  );
endmodule

// File: rtl/vid_xbar_chk.sv
module vid_xbar_chk #(
  parameter int N_IN  = 2,
  parameter int N_OUT = 2
) (
  input logic                                  clk,
  input logic                                  rst,
  input logic                                  en_q,
  input logic                                  commit_now,
  input logic [N_OUT-1:0]                      busy,
  input logic [N_OUT*$clog2(N_IN+1)-1:0]       stg_sel,
  input logic [N_OUT*$clog2(N_IN+1)-1:0]       act_sel,
  input logic [N_OUT-1:0]                      out_valid,
  input logic [N_IN-1:0]                       in_ready
);
  localparam int SW = $clog2(N_IN + 1);

  a_r2_quiet_when_off: assert property (@(posedge clk) disable iff (rst)
    !en_q |-> (out_valid == '0 && in_ready == '0));

  a_r3_route_only_on_commit: assert property (@(posedge clk) disable iff (rst)
    !commit_now |=> $stable(act_sel));

  a_r5_commit_loads_stage: assert property (@(posedge clk) disable iff (rst)
    commit_now |=> (act_sel == $past(stg_sel)));

  a_r5_no_beat_on_commit: assert property (@(posedge clk) disable iff (rst)
    commit_now |-> (out_valid == '0 && in_ready == '0));

  a_r6_hold_in_packet: assert property (@(posedge clk) disable iff (rst)
    (|busy) |=> $stable(act_sel));

  for (genvar k = 0; k < N_OUT; k++) begin : g_k
    a_r9_off_is_silent: assert property (@(posedge clk) disable iff (rst)
      (act_sel[k*SW +: SW] == '0) |-> !out_valid[k]);
  end
endmodule

bind vid_xbar vid_xbar_chk #(.N_IN(N_IN), .N_OUT(N_OUT)) u_chk (
  .clk(clk), .rst(rst), .en_q(en_q), .commit_now(commit_now), .busy(busy),
  .stg_sel(stg_sel), .act_sel(act_sel), .out_valid(out_valid), .in_ready(in_ready)
);

// File: tb/sim_vid_xbar.sv
module sim_vid_xbar;
  localparam int DW = 24;
  localparam int AW = 4;
  localparam int CW = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [AW-1:0] csr_addr = '0;
  logic csr_wr = 1'b0, csr_rd = 1'b0;
  logic [CW-1:0] csr_wdata = '0, csr_rdata;
  logic [1:0] in_valid = '0, in_ready, in_sop = '0, in_eop = '0;
  logic [2*DW-1:0] in_data;
  logic [1:0] out_valid, out_ready = '0, out_sop, out_eop;
  logic [2*DW-1:0] out_data;

  int n_run = 0, n_fail = 0;

  localparam logic [DW-1:0] D0 = 24'h01_0055;
  localparam logic [DW-1:0] D1 = 24'h02_00AA;
  assign in_data = {D1, D0};

  always #2 clk = ~clk;

  vid_xbar #(.N_IN(2), .N_OUT(2), .DW(DW), .AW(AW), .CW(CW)) u0 (
    .clk(clk), .rst(rst), .csr_addr(csr_addr), .csr_wr(csr_wr),
    .csr_wdata(csr_wdata), .csr_rd(csr_rd), .csr_rdata(csr_rdata),
    .in_valid(in_valid), .in_ready(in_ready), .in_sop(in_sop),
    .in_eop(in_eop), .in_data(in_data), .out_valid(out_valid),
    .out_ready(out_ready), .out_sop(out_sop), .out_eop(out_eop),
    .out_data(out_data)
  );

  // {sel0, sel1, in_valid, out_ready, exp out_valid, exp in_ready, pad}
  localparam int NV = 8;
  localparam logic [15:0] VEC [NV] = '{
    {2'd1, 2'd2, 2'b11, 2'b11, 2'b11, 2'b11, 4'h0},
    {2'd2, 2'd1, 2'b01, 2'b11, 2'b10, 2'b11, 4'h0},
    {2'd1, 2'd0, 2'b11, 2'b11, 2'b01, 2'b01, 4'h0},
    {2'd1, 2'd1, 2'b11, 2'b11, 2'b01, 2'b01, 4'h0},
    {2'd0, 2'd0, 2'b11, 2'b11, 2'b00, 2'b00, 4'h0},
    {2'd3, 2'd2, 2'b11, 2'b10, 2'b10, 2'b10, 4'h0},
    {2'd2, 2'd1, 2'b11, 2'b01, 2'b11, 2'b10, 4'h0},
    {2'd1, 2'd1, 2'b11, 2'b10, 2'b01, 2'b00, 4'h0}
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(posedge clk); #1;
    csr_addr = AW'(a); csr_wdata = CW'(d); csr_wr = 1'b1;
    @(posedge clk); #1;
    csr_wr = 1'b0;
  endtask

  task automatic rd(input int a, output logic [CW-1:0] v);
    @(posedge clk); #1;
    csr_addr = AW'(a); csr_rd = 1'b1;
    @(posedge clk); #1;
    csr_rd = 1'b0;
    v = csr_rdata;
  endtask

  task automatic route(input int s0, input int s1);
    wr(3, s0); wr(4, s1); wr(2, 1);
    repeat (3) @(posedge clk);
    #1;
  endtask

  function automatic logic [DW-1:0] exp_data(input int s);
    if (s == 1) return D0;
    if (s == 2) return D1;
    return '0;
  endfunction

  // no-mix monitor: each output packet keeps one source tag (R6)
  logic [7:0] tag [2];
  logic       open [2];
  initial begin
    open[0] = 1'b0; open[1] = 1'b0; tag[0] = '0; tag[1] = '0;
    forever begin
      @(negedge clk);
      for (int k = 0; k < 2; k++) begin
        if (!rst && out_valid[k] && out_ready[k]) begin
          if (out_sop[k]) begin
            tag[k] = out_data[k*DW + 16 +: 8];
            open[k] = !out_eop[k];
          end else if (open[k]) begin
            chk("R6 packet source", 64'(out_data[k*DW + 16 +: 8]), 64'(tag[k]));
            if (out_eop[k]) open[k] = 1'b0;
          end
        end
      end
    end
  end

  initial begin
    #400000;
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [CW-1:0] v;
    logic d0_ok;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 out_valid", 64'(out_valid), 0);
    chk("R1 in_ready", 64'(in_ready), 0);
    rd(0, v); chk("R1 enable reg", 64'(v), 0);
    rd(2, v); chk("R1 commit reg", 64'(v), 0);
    rd(3, v); chk("R1 sel reg", 64'(v), 0);

    // R2 disabled: routed but no traffic
    route(1, 2);
    in_valid = 2'b11; out_ready = 2'b11;
    @(negedge clk);
    chk("R2 out_valid off", 64'(out_valid), 0);
    chk("R2 in_ready off", 64'(in_ready), 0);
    in_valid = 2'b00;
    wr(0, 1);
    rd(0, v); chk("R12 enable readback", 64'(v), 1);

    // vector table: R7 R8 R9 R10 R11
    for (int n = 0; n < NV; n++) begin
      logic [15:0] e;
      e = VEC[n];
      route(int'(e[15:14]), int'(e[13:12]));
      in_valid = e[11:10]; out_ready = e[9:8];
      @(negedge clk);
      chk($sformatf("R11 vec%0d out_valid", n), 64'(out_valid), 64'(e[7:6]));
      chk($sformatf("R8 vec%0d in_ready", n), 64'(in_ready), 64'(e[5:4]));
      d0_ok = (e[15:14] == 2'd1 || e[15:14] == 2'd2);
      chk($sformatf("R7 vec%0d out0 data", n), 64'(out_data[0 +: DW]),
          64'(d0_ok ? exp_data(int'(e[15:14])) : '0));
      chk($sformatf("R10 R9 vec%0d out1 data", n), 64'(out_data[DW +: DW]),
          64'((e[13:12] != e[15:14] || !d0_ok) ? exp_data(int'(e[13:12])) : '0));
      @(posedge clk); #1;
      in_valid = 2'b00;
    end

    // R3 staging, R4/R5/R6 commit across an open packet
    route(1, 0);
    out_ready = 2'b01;
    wr(3, 2);
    rd(3, v); chk("R3 staged readback", 64'(v), 2);
    in_valid = 2'b10;
    @(negedge clk);
    chk("R3 active unchanged", 64'(out_valid[0]), 0);
    // open packet on in0
    @(posedge clk); #1;
    in_valid = 2'b01; in_sop = 2'b01; in_eop = 2'b00;
    @(posedge clk); #1;
    in_valid = 2'b00; in_sop = 2'b00;
    wr(2, 1);
    rd(2, v); chk("R4 pending", 64'(v), 1);
    in_valid = 2'b11;
    @(negedge clk);
    chk("R6 still in0", 64'(out_data[0 +: DW]), 64'(D0));
    chk("R6 valid mid-packet", 64'(out_valid[0]), 1);
    @(posedge clk); #1;
    in_valid = 2'b01; in_eop = 2'b01;
    @(posedge clk); #1;
    in_valid = 2'b00; in_eop = 2'b00;
    repeat (2) @(posedge clk);
    rd(2, v); chk("R4 cleared", 64'(v), 0);
    in_valid = 2'b10;
    @(negedge clk);
    chk("R5 new route valid", 64'(out_valid[0]), 1);
    chk("R5 new route data", 64'(out_data[0 +: DW]), 64'(D1));
    in_valid = 2'b00;

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule